// File: doc/BRIEF.md
# Shared-Trie Multi-Table Longest-Prefix Lookup Pipeline

This block resolves destination addresses against several virtual forwarding tables that all live in one binary trie. Every trie node has a left child, a right child, one array pointer and a membership bitmap with one bit per table. The bit for a table is set when the node's prefix is a route in that table. A lookup carries an address and a table ID. It walks the trie one level per pipeline stage, and each stage has a private node memory. At each node it tests the bitmap bit picked by the table ID. When that bit is set, the node's array pointer becomes the best match so far.

After the last trie level, one more stage reads a row of next-hop pointers from a separate memory, using the best array pointer as the row address. The entry at the table-ID position is the result. A final register presents that result on the output. A new lookup may enter on every clock, and results leave in the order they arrived. Software maintains the contents through two write ports. One writes a whole node word into a chosen level's memory. The other writes a single next-hop entry of a row.

Top module: `vrt_lpm_pipe`

## Requirements
- R1: While `rst` is high, and on the first cycles after it is released, `res_valid` stays 0, including when `lk_valid` was held high during reset.
- R2: A node word is laid out MSB to LSB as {left[PTR_W], right[PTR_W], array[PTR_W], bitmap[N_TBL]}. Bitmap bit i marks the node as a route of table i only, so a lookup with table ID i matches only nodes whose bit i is 1.
- R3: Where several visited nodes match, the deepest one supplies the array pointer.
- R4: The walk starts at entry 0 of the level-0 memory. Address bits are consumed MSB first. At level k, bit ADDR_W-1-k equal to 0 follows the left child and 1 follows the right child, and a child pointer is an entry index in the level k+1 memory.
- R5: A child pointer of 0 ends the walk. The lookup passes through the remaining levels unchanged and keeps the pointer it has recorded.
- R6: A result is registered exactly ADDR_W+2 rising edges after the edge that accepts the lookup. Lookups may arrive on consecutive cycles, results keep input order, and `res_valid` is 0 in every cycle that has no result.
- R7: The result is the entry at offset table ID of the next-hop row addressed by the low bits of the recorded array pointer.
- R8: When no visited node matches for the table ID, the result is 0 and `res_valid` is still 1.
- R9: A node write replaces one entry of one level memory, and later lookups see the new node. A next-hop write replaces one entry of a row and leaves the other entries of that row unchanged.
- R10: A node at level ADDR_W (full-length prefix) can match, and it wins over every shorter match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | ADDR_W | Destination address |
| lk_tid | input | TID_W | Virtual table ID |
| res_valid | output | 1 | Result present |
| res_nh | output | NH_W | Next-hop pointer, 0 = no route |
| node_we | input | 1 | Node memory write strobe |
| node_level | input | LVL_W | Trie level (memory) to write |
| node_idx | input | IDX_W | Entry index within that level |
| node_word | input | NODE_W | Node word {left, right, array, bitmap} |
| nh_we | input | 1 | Next-hop entry write strobe |
| nh_row | input | AIDX_W | Next-hop row |
| nh_tid | input | TID_W | Entry within the row (table ID) |
| nh_val | input | NH_W | Next-hop pointer to store |

## Verification
A wrong recorded pointer or a lost match flag in any stage shows up as a wrong `res_nh` on the one result that carries it, exactly ADDR_W+2 edges after acceptance. Neighbouring lookups are unaffected, so the vector table sends each case with a distinct address and table pair and back-to-back cycles to tie every miss to one stage. A broken valid chain or a changed stage count shows first as a `res_valid` at the wrong edge, because every cycle is compared, idle cycles included. Stale memory effects after a write show on the next lookup that takes the rewritten path.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

   localparam int unsigned NH_W_DEF = 8;
   localparam int unsigned PTR_W_DEF = 21;

   function automatic int unsigned idx_width(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

   function automatic int unsigned node_width(input int unsigned ptr_w, input int unsigned n_tbl);
      return 3 * ptr_w + n_tbl;
   endfunction

endpackage

// File: rtl/vrt_node_ram.sv
module vrt_node_ram #(
   parameter int unsigned WIDTH = 67,
   parameter int unsigned DEPTH = 32,
   localparam int unsigned IDX_W = vrt_pkg::idx_width(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [IDX_W-1:0] raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/vrt_level_stage.sv
module vrt_level_stage #(
   parameter int unsigned LEVEL  = 0,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned N_TBL  = 4,
   parameter int unsigned PTR_W  = 21,
   parameter int unsigned DEPTH  = 32,
   localparam int unsigned TID_W  = vrt_pkg::idx_width(N_TBL),
   localparam int unsigned IDX_W  = vrt_pkg::idx_width(DEPTH),
   localparam int unsigned NODE_W = vrt_pkg::node_width(PTR_W, N_TBL)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_active,
   input  logic [PTR_W-1:0]  in_ptr,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [TID_W-1:0]  in_tid,
   input  logic [PTR_W-1:0]  in_best,
   input  logic              in_found,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [NODE_W-1:0] wr_word,
   output logic              out_valid,
   output logic              out_active,
   output logic [PTR_W-1:0]  out_ptr,
   output logic [ADDR_W-1:0] out_addr,
   output logic [TID_W-1:0]  out_tid,
   output logic [PTR_W-1:0]  out_best,
   output logic              out_found
);

   localparam logic [TID_W:0] N_TBL_V = (TID_W+1)'(N_TBL);

   logic [NODE_W-1:0] rd_word;
   logic              v_q;
   logic              act_q;
   logic [ADDR_W-1:0] addr_q;
   logic [TID_W-1:0]  tid_q;
   logic [PTR_W-1:0]  best_q;
   logic              found_q;

   logic [PTR_W-1:0]  left_w;
   logic [PTR_W-1:0]  right_w;
   logic [PTR_W-1:0]  arr_w;
   logic [N_TBL-1:0]  bmp_w;
   logic              tid_ok;
   logic              sel_bit;
   logic              hit;

   vrt_node_ram #(
      .WIDTH (NODE_W),
      .DEPTH (DEPTH)
   ) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_idx),
      .wdata (wr_word),
      .raddr (in_ptr[IDX_W-1:0]),
      .rdata (rd_word)
   );

   generate
      if (PTR_W > IDX_W) begin : g_ptr_hi
         logic unused_ptr_hi;
         assign unused_ptr_hi = ^in_ptr[PTR_W-1:IDX_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q     <= 1'b0;
         act_q   <= 1'b0;
         addr_q  <= '0;
         tid_q   <= '0;
         best_q  <= '0;
         found_q <= 1'b0;
      end else begin
         v_q     <= in_valid;
         act_q   <= in_valid & in_active;
         addr_q  <= in_addr;
         tid_q   <= in_tid;
         best_q  <= in_best;
         found_q <= in_found;
      end
   end

   assign left_w  = rd_word[NODE_W-1 -: PTR_W];
   assign right_w = rd_word[NODE_W-1-PTR_W -: PTR_W];
   assign arr_w   = rd_word[N_TBL+PTR_W-1 -: PTR_W];
   assign bmp_w   = rd_word[N_TBL-1:0];

   assign tid_ok  = ({1'b0, tid_q} < N_TBL_V);
   assign sel_bit = |(bmp_w & (N_TBL'(1) << tid_q));
   assign hit     = v_q & act_q & tid_ok & sel_bit;

   assign out_valid = v_q;
   assign out_addr  = addr_q;
   assign out_tid   = tid_q;
   assign out_best  = hit ? arr_w : best_q;
   assign out_found = found_q | hit;

   generate
      if (LEVEL < ADDR_W) begin : g_branch
         logic             dir_bit;
         logic [PTR_W-1:0] child;
         assign dir_bit    = addr_q[ADDR_W-1-LEVEL];
         assign child      = dir_bit ? right_w : left_w;
         assign out_ptr    = child;
         assign out_active = v_q & act_q & (child != '0);
      end else begin : g_last
         logic unused_kids;
         assign unused_kids = ^{left_w, right_w};
         assign out_ptr     = '0;
         assign out_active  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/vrt_nh_stage.sv
module vrt_nh_stage #(
   parameter int unsigned N_TBL     = 4,
   parameter int unsigned PTR_W     = 21,
   parameter int unsigned NH_W      = 8,
   parameter int unsigned ARR_DEPTH = 64,
   localparam int unsigned TID_W  = vrt_pkg::idx_width(N_TBL),
   localparam int unsigned AIDX_W = vrt_pkg::idx_width(ARR_DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_found,
   input  logic [PTR_W-1:0]  in_best,
   input  logic [TID_W-1:0]  in_tid,
   input  logic              wr_en,
   input  logic [AIDX_W-1:0] wr_row,
   input  logic [TID_W-1:0]  wr_tid,
   input  logic [NH_W-1:0]   wr_val,
   output logic              out_valid,
   output logic [NH_W-1:0]   out_nh
);

   localparam logic [TID_W:0] N_TBL_V = (TID_W+1)'(N_TBL);

   logic [N_TBL-1:0][NH_W-1:0] tbl [ARR_DEPTH];
   logic [N_TBL-1:0][NH_W-1:0] row_q;
   logic                       v_q;
   logic                       found_q;
   logic [TID_W-1:0]           tid_q;
   logic                       wr_ok;
   logic                       tid_ok;
   logic                       ov_q;
   logic [NH_W-1:0]            nh_q;

   generate
      if (PTR_W > AIDX_W) begin : g_best_hi
         logic unused_best_hi;
         assign unused_best_hi = ^in_best[PTR_W-1:AIDX_W];
      end
   endgenerate

   assign wr_ok = wr_en & ({1'b0, wr_tid} < N_TBL_V);

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         tbl[wr_row][wr_tid] <= wr_val;
      end
      row_q <= tbl[in_best[AIDX_W-1:0]];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q     <= 1'b0;
         found_q <= 1'b0;
         tid_q   <= '0;
      end else begin
         v_q     <= in_valid;
         found_q <= in_valid & in_found;
         tid_q   <= in_tid;
      end
   end

   assign tid_ok = ({1'b0, tid_q} < N_TBL_V);

   always_ff @(posedge clk) begin
      if (rst) begin
         ov_q <= 1'b0;
         nh_q <= '0;
      end else begin
         ov_q <= v_q;
         nh_q <= (v_q && found_q && tid_ok) ? row_q[tid_q] : '0;
      end
   end

   assign out_valid = ov_q;
   assign out_nh    = nh_q;

   // R6: one result two edges after each valid entry into this stage, none otherwise
   p_cadence_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##2 out_valid);
   p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> ##2 !out_valid);

   // R8: a lookup that matched nothing yields a valid zero
   p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_found) |-> ##2 (out_valid && out_nh == '0));

endmodule

// File: rtl/vrt_lpm_pipe.sv
module vrt_lpm_pipe #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned N_TBL      = 4,
   parameter int unsigned PTR_W      = vrt_pkg::PTR_W_DEF,
   parameter int unsigned NH_W       = vrt_pkg::NH_W_DEF,
   parameter int unsigned NODE_DEPTH = 32,
   parameter int unsigned ARR_DEPTH  = 64,
   localparam int unsigned NS     = ADDR_W + 1,
   localparam int unsigned TID_W  = vrt_pkg::idx_width(N_TBL),
   localparam int unsigned IDX_W  = vrt_pkg::idx_width(NODE_DEPTH),
   localparam int unsigned AIDX_W = vrt_pkg::idx_width(ARR_DEPTH),
   localparam int unsigned LVL_W  = vrt_pkg::idx_width(NS),
   localparam int unsigned NODE_W = vrt_pkg::node_width(PTR_W, N_TBL)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic [TID_W-1:0]  lk_tid,
   output logic              res_valid,
   output logic [NH_W-1:0]   res_nh,
   input  logic              node_we,
   input  logic [LVL_W-1:0]  node_level,
   input  logic [IDX_W-1:0]  node_idx,
   input  logic [NODE_W-1:0] node_word,
   input  logic              nh_we,
   input  logic [AIDX_W-1:0] nh_row,
   input  logic [TID_W-1:0]  nh_tid,
   input  logic [NH_W-1:0]   nh_val
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (N_TBL < 2) begin : g_bad_tbl
         $error("N_TBL must be at least 2");
      end
      if (NODE_DEPTH < 2 || NODE_DEPTH > (1 << PTR_W)) begin : g_bad_depth
         $error("NODE_DEPTH must be within 2 .. 2**PTR_W");
      end
      if (ARR_DEPTH < 2 || ARR_DEPTH > (1 << PTR_W)) begin : g_bad_arr
         $error("ARR_DEPTH must be within 2 .. 2**PTR_W");
      end
      if (PTR_W < IDX_W || PTR_W > 30) begin : g_bad_ptr
         $error("PTR_W must cover the node index and stay below 31 bits");
      end
      if (NH_W < 1) begin : g_bad_nh
         $error("NH_W must be at least 1");
      end
   endgenerate

   // chain index k is the input of level k; index NS is the output of the last level
   logic              v_c     [NS+1];
   logic              act_c   [NS+1];
   logic [PTR_W-1:0]  ptr_c   [NS+1];
   logic [ADDR_W-1:0] adr_c   [NS+1];
   logic [TID_W-1:0]  tid_c   [NS+1];
   logic [PTR_W-1:0]  best_c  [NS+1];
   logic              found_c [NS+1];

   assign v_c[0]     = lk_valid;
   assign act_c[0]   = 1'b1;
   assign ptr_c[0]   = '0;
   assign adr_c[0]   = lk_addr;
   assign tid_c[0]   = lk_tid;
   assign best_c[0]  = '0;
   assign found_c[0] = 1'b0;

   genvar k;
   generate
      for (k = 0; k < NS; k++) begin : g_lvl
         logic lvl_we;
         assign lvl_we = node_we & (node_level == LVL_W'(k));

         vrt_level_stage #(
            .LEVEL  (k),
            .ADDR_W (ADDR_W),
            .N_TBL  (N_TBL),
            .PTR_W  (PTR_W),
            .DEPTH  (NODE_DEPTH)
         ) u_stage (
            .clk        (clk),
            .rst        (rst),
            .in_valid   (v_c[k]),
            .in_active  (act_c[k]),
            .in_ptr     (ptr_c[k]),
            .in_addr    (adr_c[k]),
            .in_tid     (tid_c[k]),
            .in_best    (best_c[k]),
            .in_found   (found_c[k]),
            .wr_en      (lvl_we),
            .wr_idx     (node_idx),
            .wr_word    (node_word),
            .out_valid  (v_c[k+1]),
            .out_active (act_c[k+1]),
            .out_ptr    (ptr_c[k+1]),
            .out_addr   (adr_c[k+1]),
            .out_tid    (tid_c[k+1]),
            .out_best   (best_c[k+1]),
            .out_found  (found_c[k+1])
         );

         if (k >= 1) begin : g_chk
            // R5: a finished walk crosses the next level without change
            p_dead_path_r5: assert property (@(posedge clk) disable iff (rst)
               (v_c[k] && !act_c[k]) |=> (!act_c[k+1] && best_c[k+1] == $past(best_c[k])
                                          && found_c[k+1] == $past(found_c[k])));
            // R3: once matched, a lookup stays matched at every deeper level
            p_found_kept_r3: assert property (@(posedge clk) disable iff (rst)
               (v_c[k] && found_c[k]) |=> found_c[k+1]);
         end
      end
   endgenerate

   logic unused_tail;
   assign unused_tail = ^{ptr_c[NS], act_c[NS], adr_c[NS]};

   vrt_nh_stage #(
      .N_TBL     (N_TBL),
      .PTR_W     (PTR_W),
      .NH_W      (NH_W),
      .ARR_DEPTH (ARR_DEPTH)
   ) u_nh (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (v_c[NS]),
      .in_found  (found_c[NS]),
      .in_best   (best_c[NS]),
      .in_tid    (tid_c[NS]),
      .wr_en     (nh_we),
      .wr_row    (nh_row),
      .wr_tid    (nh_tid),
      .wr_val    (nh_val),
      .out_valid (res_valid),
      .out_nh    (res_nh)
   );

   // R1: the output stays quiet on the edge after a reset cycle
   p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !res_valid);

endmodule

// File: tb/vrt_lpm_pipe_test.sv
`timescale 1ns/1ps
module vrt_lpm_pipe_test;

   localparam int ADDR_W = 8;
   localparam int N_TBL  = 4;
   localparam int PTR_W  = 21;
   localparam int NH_W   = 8;
   localparam int NDEP   = 32;
   localparam int ADEP   = 64;
   localparam int LAT    = ADDR_W + 3;   // issue-cycle to result-cycle distance in bench cycles
   localparam int NODE_W = 3*PTR_W + N_TBL;

   typedef struct packed {
      logic [7:0] addr;
      logic [1:0] tid;
      logic [7:0] nh;
      logic [7:0] req;
   } vec_t;

   // address, table ID, expected next hop, requirement number
   localparam int NVEC = 13;
   localparam vec_t VECS [NVEC] = '{
      '{8'h00, 2'd0, 8'h41, 8'd3},   // R3 root then 00*
      '{8'h00, 2'd1, 8'h42, 8'd2},   // R2 0* and 00* for table 1
      '{8'h00, 2'd2, 8'h00, 8'd8},   // R8 nothing for table 2
      '{8'h40, 2'd1, 8'h22, 8'd5},   // R5 null right child ends walk
      '{8'h40, 2'd0, 8'h11, 8'd5},   // R5 keeps default route
      '{8'h80, 2'd2, 8'h33, 8'd7},   // R7 entry 2 of row 3
      '{8'h80, 2'd3, 8'h00, 8'd8},   // R8
      '{8'hC0, 2'd3, 8'h54, 8'd4},   // R4 right, right, left
      '{8'hC0, 2'd0, 8'h61, 8'd10},  // R10 full-length match
      '{8'hDF, 2'd0, 8'h61, 8'd10},  // R10 other leaf path
      '{8'hE0, 2'd0, 8'h31, 8'd4},   // R4 null right at 11*
      '{8'hE0, 2'd2, 8'h33, 8'd2},   // R2 bit 2 only
      '{8'hC0, 2'd1, 8'h00, 8'd8}    // R8
   };

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              lk_valid = 1'b0;
   logic [ADDR_W-1:0] lk_addr = '0;
   logic [1:0]        lk_tid = '0;
   logic              res_valid;
   logic [NH_W-1:0]   res_nh;
   logic              node_we = 1'b0;
   logic [3:0]        node_level = '0;
   logic [4:0]        node_idx = '0;
   logic [NODE_W-1:0] node_word = '0;
   logic              nh_we = 1'b0;
   logic [5:0]        nh_row = '0;
   logic [1:0]        nh_tid = '0;
   logic [NH_W-1:0]   nh_val = '0;

   int  cyc = 0;
   int  checks = 0;
   int  fails = 0;
   bit  mon_en = 1'b0;
   bit  done = 1'b0;
   bit  ev [1024];
   logic [7:0] en [1024];
   int  er [1024];

   always #4 clk = ~clk;

   vrt_lpm_pipe #(
      .ADDR_W (ADDR_W), .N_TBL (N_TBL), .PTR_W (PTR_W), .NH_W (NH_W),
      .NODE_DEPTH (NDEP), .ARR_DEPTH (ADEP)
   ) uut (
      .clk (clk), .rst (rst),
      .lk_valid (lk_valid), .lk_addr (lk_addr), .lk_tid (lk_tid),
      .res_valid (res_valid), .res_nh (res_nh),
      .node_we (node_we), .node_level (node_level), .node_idx (node_idx), .node_word (node_word),
      .nh_we (nh_we), .nh_row (nh_row), .nh_tid (nh_tid), .nh_val (nh_val)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // per-cycle comparison; idle slots expect no result (R6)
   always @(negedge clk) begin
      if (mon_en && !done) begin
         int s;
         s = cyc % 1024;
         checks++;
         if (res_valid !== ev[s] || (ev[s] && res_nh !== en[s])) begin
            fails++;
            $display("FAIL R%0d cycle %0d: valid=%b nh=%h, expected valid=%b nh=%h",
                     (er[s] == 0) ? 6 : er[s], cyc, res_valid, res_nh, ev[s], en[s]);
         end
         ev[s] = 1'b0;
         er[s] = 0;
      end
   end

   function automatic logic [NODE_W-1:0] nword(input int l, input int r, input int a, input logic [3:0] b);
      return {PTR_W'(l), PTR_W'(r), PTR_W'(a), b};
   endfunction

   task automatic wr_node(input int lvl, input int idx, input int l, input int r, input int a, input logic [3:0] b);
      node_we = 1'b1; node_level = 4'(lvl); node_idx = 5'(idx); node_word = nword(l, r, a, b);
      @(negedge clk);
      node_we = 1'b0;
   endtask

   task automatic wr_nh(input int row, input int tid, input logic [7:0] v);
      nh_we = 1'b1; nh_row = 6'(row); nh_tid = 2'(tid); nh_val = v;
      @(negedge clk);
      nh_we = 1'b0;
   endtask

   task automatic issue(input logic [7:0] a, input logic [1:0] t, input logic [7:0] nh, input int req);
      int s;
      s = (cyc + LAT) % 1024;
      ev[s] = 1'b1; en[s] = nh; er[s] = req;
      lk_valid = 1'b1; lk_addr = a; lk_tid = t;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 20000);
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      // R1: lookups offered during reset must not produce results
      lk_valid = 1'b1; lk_addr = 8'h00;
      idle(6);
      lk_valid = 1'b0;
      rst = 1'b0;
      checks++;
      if (res_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1 after reset: valid=%b, expected valid=0", res_valid);
      end
      mon_en = 1'b1;

      // trie: level, index, left, right, array, bitmap (bit i = table i), R2
      wr_node(0, 0, 1, 2, 1, 4'b0001);
      wr_node(1, 1, 1, 0, 2, 4'b0010);
      wr_node(1, 2, 0, 2, 3, 4'b0101);
      wr_node(2, 1, 0, 0, 4, 4'b0011);
      wr_node(2, 2, 1, 0, 5, 4'b1000);
      for (int l = 3; l < ADDR_W; l++) wr_node(l, 1, 1, 1, 0, 4'b0000);
      wr_node(ADDR_W, 1, 0, 0, 6, 4'b0001);
      for (int r = 1; r <= 6; r++)
         for (int t = 0; t < N_TBL; t++)
            wr_nh(r, t, 8'((r << 4) | (t + 1)));
      idle(4);

      // vector table, back to back (R6 ordering and cadence)
      for (int i = 0; i < NVEC; i++)
         issue(VECS[i].addr, VECS[i].tid, VECS[i].nh, int'(VECS[i].req));
      idle(LAT + 2);

      // gaps between lookups: idle cycles must stay empty (R6)
      issue(8'hC0, 2'd0, 8'h61, 6);
      idle(3);
      issue(8'h40, 2'd1, 8'h22, 6);
      idle(LAT + 2);

      // R9: remove prefix 1* from table 2
      wr_node(1, 2, 0, 2, 3, 4'b0001);
      idle(2);
      issue(8'h80, 2'd2, 8'h00, 9);   // R9 now no route
      issue(8'h80, 2'd0, 8'h31, 9);   // R9 table 0 unaffected
      idle(LAT + 2);

      // R9: single-entry next-hop write keeps the rest of the row
      wr_nh(4, 0, 8'h77);
      idle(2);
      issue(8'h00, 2'd0, 8'h77, 9);   // R9 rewritten entry
      issue(8'h00, 2'd1, 8'h42, 9);   // R9 neighbour entry kept
      idle(LAT + 2);

      finish_run();
   end

endmodule